// File: doc/BRIEF.md
# Dual Programmable Interval Timer

A register-mapped interval timer with one or two identical 32-bit counting channels; the channel count is fixed at build time. Software sets a start value in a channel's load register. It then writes the channel's control register with the run bit set. From then on the counter takes one step per clock, either downward to zero or upward to all-ones. On reaching that end value it raises the channel's event flag. It then either reloads and keeps going or halts at the end value. One level interrupt line merges the armed flags of all channels.

The bus is a plain word-addressed port with no handshake. A write happens on the clock edge where the write strobe is high. A read strobe on one edge puts the selected word on the read data port for the following cycle. The bus carries no streamed data, so it has no valid/ready pair. The bus never stalls and has no back-pressure.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register and counter of every channel reads zero, no channel runs and `irq` is low.
- R2: The word address selects channel `addr[ADDR_W-1:2]` and register `addr[1:0]`: 0 control, 1 start value, 2 live count, 3 unused. Writes to offset 3 have no effect and reads of it return zero. Read data appears on `bus_rdata` the cycle after the edge that samples `bus_rd_en`.
- R3: The control register keeps bits 10:0 of a write and reads zero above them. Bit 1 selects down counting (1) or up counting (0). Bit 4 is reload, bit 6 is interrupt arm, bit 7 is run and bit 8 is the event flag. Every control write leaves the event flag clear, whatever is written to bit 8. The other low bits are kept but change nothing.
- R4: The start-value register keeps all 32 bits. Writing it while a channel runs does not alter the count in progress.
- R5: A control write with bit 7 set loads the count from the start value and starts the channel. A control write with bit 7 clear stops the channel, and the count holds its value.
- R6: In down mode, with start value L, the event flag is set on the (L+1)-th edge after the starting write.
- R7: In up mode, with start value L, the event flag is set on the (2^32-1-L+1)-th edge after the starting write.
- R8: At the end value, a channel without reload stops with the count held at the end value. A channel with reload copies the start value into the count and keeps counting.
- R9: `irq` is high exactly when some channel has both its event flag and its interrupt-arm bit set. It follows register changes with no added cycle.
- R10: In a one-channel build the addresses of channel 1 ignore writes and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Word address: channel and register |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt |

## Verification
Register state, the run state and `irq` change on the write edge itself. The count changes on every later edge. A read returns the state as it stood before the capturing edge, one cycle after the strobe. The bench drives and samples only on falling edges, so the sample after the starting write is cycle 0. A flag due on edge L+1 is checked low at sample L and high at sample L+1. Read expectations are worked out from the edge at which the strobe is captured.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam int CTRL_W   = 11;
  localparam int B_DOWN   = 1;
  localparam int B_RELOAD = 4;
  localparam int B_IE     = 6;
  localparam int B_RUN    = 7;
  localparam int B_FLAG   = 8;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_START = 2'd1,
    REG_COUNT = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/timer_regdec.sv
`timescale 1ns/1ps
module timer_regdec
  import timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic [CH_W-1:0]   ch_idx,
  output logic              ch_ok,
  output reg_sel_e          reg_sel,
  output logic [NUM_CH-1:0] ctrl_we,
  output logic [NUM_CH-1:0] start_we
);
  always_comb begin
    ch_idx  = addr[ADDR_W-1:2];
    reg_sel = reg_sel_e'(addr[1:0]);
    ch_ok   = (32'(ch_idx) < 32'(NUM_CH));
    for (int c = 0; c < NUM_CH; c++) begin
      ctrl_we[c]  = wr_en && ch_ok && (ch_idx == CH_W'(c)) && (reg_sel == REG_CTRL);
      start_we[c] = wr_en && ch_ok && (ch_idx == CH_W'(c)) && (reg_sel == REG_START);
    end
  end
endmodule

// File: rtl/timer_channel.sv
`timescale 1ns/1ps
module timer_channel
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              start_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] start_q,
  output logic [DATA_W-1:0] count_q,
  output logic              run_q,
  output logic              irq_req
);
  logic at_end;

  always_comb begin
    at_end  = ctrl_q[B_DOWN] ? (count_q == '0) : (count_q == '1);
    irq_req = ctrl_q[B_FLAG] & ctrl_q[B_IE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= '0;
      count_q <= '0;
      run_q   <= 1'b0;
    end else begin
      if (start_we) start_q <= wdata;
      if (ctrl_we) begin
        ctrl_q <= wdata[CTRL_W-1:0] & ~(CTRL_W'(1) << B_FLAG);
        if (wdata[B_RUN]) begin
          run_q   <= 1'b1;
          count_q <= start_q;
        end else begin
          run_q <= 1'b0;
        end
      end else if (run_q) begin
        if (at_end) begin
          ctrl_q[B_FLAG] <= 1'b1;
          if (ctrl_q[B_RELOAD]) count_q <= start_q;
          else                  run_q   <= 1'b0;
        end else if (ctrl_q[B_DOWN]) begin
          count_q <= count_q - 1'b1;
        end else begin
          count_q <= count_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/timer_irq_merge.sv
`timescale 1ns/1ps
module timer_irq_merge #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] req,
  output logic              irq
);
  always_comb begin
    irq = 1'b0;
    for (int c = 0; c < NUM_CH; c++) irq = irq | req[c];
  end
endmodule

// File: rtl/dual_interval_timer.sv
`timescale 1ns/1ps
module dual_interval_timer
  import timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [CH_W-1:0]                ch_idx;
  logic                           ch_ok;
  reg_sel_e                       reg_sel;
  logic [NUM_CH-1:0]              ctrl_we, start_we, run_v, req_v;
  logic [NUM_CH-1:0][CTRL_W-1:0]  ctrl_v;
  logic [NUM_CH-1:0][DATA_W-1:0]  start_v, cnt_v;
  logic [DATA_W-1:0]              rd_next;

  timer_regdec #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .addr(bus_addr), .wr_en(bus_wr_en), .ch_idx(ch_idx), .ch_ok(ch_ok),
    .reg_sel(reg_sel), .ctrl_we(ctrl_we), .start_we(start_we)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    timer_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we[c]), .start_we(start_we[c]),
      .wdata(bus_wdata), .ctrl_q(ctrl_v[c]), .start_q(start_v[c]),
      .count_q(cnt_v[c]), .run_q(run_v[c]), .irq_req(req_v[c])
    );
  end

  timer_irq_merge #(.NUM_CH(NUM_CH)) u_irq (.req(req_v), .irq(irq));

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_ok && (ch_idx == CH_W'(c))) begin
        case (reg_sel)
          REG_CTRL:  rd_next = DATA_W'(ctrl_v[c]);
          REG_START: rd_next = start_v[c];
          REG_COUNT: rd_next = cnt_v[c];
          default:   rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/timer_checker.sv
`timescale 1ns/1ps
module timer_checker
  import timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_wr_en,
  input logic                          irq,
  input logic [NUM_CH-1:0]             run_v,
  input logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_v,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt_v
);
  logic armed_any;
  always_comb begin
    armed_any = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      armed_any = armed_any | (ctrl_v[c][B_FLAG] & ctrl_v[c][B_IE]);
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!irq && run_v == '0));

  p_irq_needs_armed_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> armed_any);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic hit_ctrl, at_end;
    always_comb begin
      hit_ctrl = bus_wr_en && (bus_addr[1:0] == 2'd0) &&
                 (32'(bus_addr[ADDR_W-1:2]) == 32'(c));
      at_end   = ctrl_v[c][B_DOWN] ? (cnt_v[c] == '0) : (cnt_v[c] == '1);
    end

    p_ctrl_write_clears_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ctrl |=> !ctrl_v[c][B_FLAG]);

    p_stopped_count_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_v[c] && !hit_ctrl) |=> $stable(cnt_v[c]));

    p_flag_rises_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_v[c][B_FLAG]) |-> ($past(run_v[c]) &&
        (($past(ctrl_v[c][B_DOWN]) && $past(cnt_v[c]) == '0) ||
         (!$past(ctrl_v[c][B_DOWN]) && $past(cnt_v[c]) == '1))));

    p_oneshot_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v[c] && at_end && !ctrl_v[c][B_RELOAD] && !hit_ctrl) |=> !run_v[c]);
  end
endmodule

bind dual_interval_timer timer_checker #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .irq(irq), .run_v(run_v), .ctrl_v(ctrl_v), .cnt_v(cnt_v)
);

// File: tb/dual_interval_timer_tb_top.sv
`timescale 1ns/1ps
module dual_interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en0 = 1'b0, wr_en1 = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  dual_interval_timer #(.NUM_CH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en0),
    .bus_wdata(wdata), .bus_rd_en(rd_en), .bus_rdata(rdata0), .irq(irq0));

  dual_interval_timer #(.NUM_CH(1)) dut1_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en1),
    .bus_wdata(wdata), .bus_rd_en(rd_en), .bus_rdata(rdata1), .irq(irq1));

  typedef struct packed {
    logic        wr;
    logic [2:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 3'd0, 32'hFFFF_F67F, 32'h0},          // R3 keep low 11 bits
    '{1'b0, 3'd0, 32'h0,         32'h0000_067F},
    '{1'b1, 3'd0, 32'h0000_0100, 32'h0},          // R3 bit 8 written, flag clear
    '{1'b0, 3'd0, 32'h0,         32'h0},
    '{1'b1, 3'd1, 32'hDEAD_BEEF, 32'h0},          // R4 start value
    '{1'b0, 3'd1, 32'h0,         32'hDEAD_BEEF},
    '{1'b1, 3'd3, 32'h1234_5678, 32'h0},          // R2 unused offset
    '{1'b0, 3'd3, 32'h0,         32'h0},
    '{1'b1, 3'd5, 32'h0000_A5A5, 32'h0},          // R2 channel 1 start value
    '{1'b0, 3'd5, 32'h0,         32'h0000_A5A5},
    '{1'b0, 3'd1, 32'h0,         32'hDEAD_BEEF},  // R2 channel 0 untouched
    '{1'b0, 3'd2, 32'h0,         32'h0}           // R5 never started
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic wr(input bit sel, input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    if (sel) wr_en1 = 1'b1; else wr_en0 = 1'b1;
    @(negedge clk);
    wr_en0 = 1'b0; wr_en1 = 1'b0;
  endtask

  task automatic rd(input bit sel, input logic [2:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = sel ? rdata1 : rdata0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk("R1 irq", {31'd0, irq0}, 32'd0);
    rd(0, 3'd0, v); chk("R1 ctrl", v, 32'd0);
    rd(0, 3'd1, v); chk("R1 start", v, 32'd0);
    rd(0, 3'd2, v); chk("R1 count", v, 32'd0);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i].wr) wr(0, VEC[i].a, VEC[i].d);
      else begin
        rd(0, VEC[i].a, v);
        chk($sformatf("R2/R3/R4 vector %0d", i), v, VEC[i].e);
      end
    end

    // R6 down, one-shot: start 5, flag on edge 6
    wr(0, 3'd1, 32'd5);
    wr(0, 3'd0, 32'h0000_00C2);
    idle(5); chk("R6 irq before end", {31'd0, irq0}, 32'd0);
    idle(1); chk("R6 irq at end", {31'd0, irq0}, 32'd1);
    rd(0, 3'd2, v); chk("R8 one-shot holds zero", v, 32'd0);
    rd(0, 3'd0, v); chk("R6 flag in ctrl", v, 32'h0000_01C2);
    wr(0, 3'd0, 32'h0000_0042);
    chk("R3 write clears flag irq", {31'd0, irq0}, 32'd0);
    rd(0, 3'd0, v); chk("R3 flag cleared", v, 32'h0000_0042);

    // R7 up: start FFFFFFFC, flag on edge 4
    wr(0, 3'd1, 32'hFFFF_FFFC);
    wr(0, 3'd0, 32'h0000_00C0);
    idle(3); chk("R7 irq before end", {31'd0, irq0}, 32'd0);
    idle(1); chk("R7 irq at end", {31'd0, irq0}, 32'd1);
    rd(0, 3'd2, v); chk("R8 up holds all-ones", v, 32'hFFFF_FFFF);

    // R8 reload: start 2, period 3
    wr(0, 3'd1, 32'd2);
    wr(0, 3'd0, 32'h0000_00D2);
    idle(3); chk("R8 reload irq", {31'd0, irq0}, 32'd1);
    idle(1);
    rd(0, 3'd2, v); chk("R8 reloaded count", v, 32'd1);
    wr(0, 3'd0, 32'h0);

    // R4 start write during run
    wr(0, 3'd1, 32'd10);
    wr(0, 3'd0, 32'h0000_00C2);
    wr(0, 3'd1, 32'd1);
    idle(9); chk("R4 run unaffected early", {31'd0, irq0}, 32'd0);
    idle(1); chk("R4 run unaffected end", {31'd0, irq0}, 32'd1);

    // R5 stop holds count
    wr(0, 3'd1, 32'd100);
    wr(0, 3'd0, 32'h0000_0082);
    idle(10);
    wr(0, 3'd0, 32'h0000_0002);
    rd(0, 3'd2, v); chk("R5 stopped count", v, 32'd90);
    idle(3);
    rd(0, 3'd2, v2); chk("R5 count stays", v2, 32'd90);

    // R9 masking and OR across channels
    wr(0, 3'd1, 32'd0);
    wr(0, 3'd0, 32'h0000_0082);
    idle(1); chk("R9 unarmed flag no irq", {31'd0, irq0}, 32'd0);
    rd(0, 3'd0, v); chk("R9 flag set unarmed", v, 32'h0000_0182);
    wr(0, 3'd5, 32'd0);
    wr(0, 3'd4, 32'h0000_00C2);
    idle(1); chk("R9 channel 1 irq", {31'd0, irq0}, 32'd1);
    wr(0, 3'd4, 32'h0);
    chk("R9 irq drops", {31'd0, irq0}, 32'd0);

    // R10 single-channel build
    wr(1, 3'd5, 32'd0);
    wr(1, 3'd4, 32'h0000_00C2);
    idle(3); chk("R10 no irq from missing channel", {31'd0, irq1}, 32'd0);
    rd(1, 3'd4, v); chk("R10 ctrl reads zero", v, 32'd0);
    wr(1, 3'd1, 32'h0000_0077);
    rd(1, 3'd1, v); chk("R10 channel 0 works", v, 32'h0000_0077);

    // R1 reset while running
    wr(0, 3'd1, 32'd50);
    wr(0, 3'd0, 32'h0000_00D2);
    idle(4);
    rst_n = 1'b0; idle(1); rst_n = 1'b1;
    chk("R1 irq after reset", {31'd0, irq0}, 32'd0);
    rd(0, 3'd2, v); chk("R1 count after reset", v, 32'd0);
    idle(2);
    rd(0, 3'd2, v); chk("R1 stays stopped", v, 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule